// File: doc/BRIEF.md
# Wakeup Flag Capture and Gating

This block holds the eight wakeup flags that decide when an always-on sensor subsystem asks the power manager to wake it. Four flags are set by edges on hardware sources: each has an enable bit and a source index that picks one line out of a source vector. The other four flags are set by a host CPU writing a trigger register, which serves as a handshake channel toward the subsystem. A single gate bit qualifies the combined wakeup request. The block presents that request, and each flag on its own line, to the power manager.

Flags stay set until software clears them. Clearing uses a level-held clear register. While clear bit n stays at 1, flag n is forced low and cannot be set again. Software holds the bit until the flag reads 0 and then drops it. Before it touches a hardware-sourced flag or its configuration, software must close the gate. A configuration write made while the gate is open is refused and recorded in a sticky error bit.

Top module: `wake_flag_ctrl`

## Requirements
- R1: After reset all flags are 0, every source configuration reads 0x00, the clear register reads 0x00, and the gate register (address 7) reads 0x01: bit 0 is gate enable = 1 and bit 1 is protocol error = 0.
- R2: Hardware flag i (flag bit i, i = 0..3) sets on the clock edge at which its selected source line is 1 and was 0 at the previous edge, provided the configuration is enabled. A source line held at 1 does not set the flag again.
- R3: A hardware flag does not set from an edge on a source that is not selected, or while its configuration is disabled.
- R4: Writing the trigger register (address 4) with data bit k = 1 sets software flag k, which is flag bit 4+k. Data bits that are 0 leave the flags unchanged.
- R5: While clear register bit n (address 6) is 1, flag n is 0 from the next edge on. Software flags clear this way without any gate procedure.
- R6: While clear bit n stays at 1, neither a source edge nor a trigger write can set flag n.
- R7: The wakeup output is 1 exactly when the gate enable is 1 and at least one flag is set. Closing the gate does not alter the flags.
- R8: A write to a configuration register (addresses 0..3) while the gate is enabled leaves that configuration unchanged and sets the protocol error bit (address 7, bit 1). The bit stays at 1 until reset.
- R9: When the gate is disabled, a write to configuration address i loads it. Bit 7 is the enable and bits 3:0 are the source index. The value reads back in the same layout.
- R10: A flag that is set stays set until its clear bit is raised. The flag register reads back at address 5, with hardware flags in bits 3:0 and software flags in bits 7:4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address (combinational read) |
| rdData | output | 8 | Read data |
| wakeSrc | input | NUM_SRC | Hardware wakeup source lines |
| wakeOut | output | 1 | Gated wakeup request to the power manager |
| wakeFlags | output | 8 | Per-flag state |

## Verification
The assertions assume that the register bus issues at most one write per cycle. They also assume that the source vector is synchronous to the clock, so that a rising edge is seen as a change between two samples. The bench drives every input on the falling clock edge, issues one write at a time and moves the source lines only between writes. It follows the gate-then-clear procedure for hardware flags, except in the two cases where it breaks that procedure on purpose to show that a configuration write is refused.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int PROG_N = 4;
  localparam int SW_N   = 4;
  localparam int FLAG_N = PROG_N + SW_N;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd6;
  localparam logic [ADDR_W-1:0] A_GATE  = 3'd7;

  // control-to-datapath strobes, at most one field active per cycle
  typedef struct packed {
    logic [PROG_N-1:0] cfgLoad;
    logic              cfgReject;
    logic              trigLoad;
    logic              clrLoad;
    logic              gateLoad;
  } strobe_t;
endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int CFG_W = SEL_W + 1
) (
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic                    gateEn,
  input  logic                    protoErr,
  input  logic [FLAG_N-1:0]       flags,
  input  logic [FLAG_N-1:0]       clrQ,
  input  logic [PROG_N*CFG_W-1:0] cfgFlat,
  output strobe_t                 strb,
  output logic [DATA_W-1:0]       rdData
);
  logic cfgHit;

  always_comb begin
    strb   = '0;
    cfgHit = wrEn && (wrAddr < ADDR_W'(PROG_N));
    for (int i = 0; i < PROG_N; i++)
      strb.cfgLoad[i] = cfgHit && !gateEn && (wrAddr == ADDR_W'(i));
    strb.cfgReject = cfgHit && gateEn;
    strb.trigLoad  = wrEn && (wrAddr == A_TRIG);
    strb.clrLoad   = wrEn && (wrAddr == A_CLR);
    strb.gateLoad  = wrEn && (wrAddr == A_GATE);
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_FLAGS: rdData = flags;
      A_CLR:   rdData = clrQ;
      A_GATE:  rdData = {{(DATA_W-2){1'b0}}, protoErr, gateEn};
      default: begin
        for (int i = 0; i < PROG_N; i++) begin
          if (rdAddr == ADDR_W'(i)) begin
            rdData[DATA_W-1]   = cfgFlat[i*CFG_W+SEL_W];
            rdData[SEL_W-1:0]  = cfgFlat[i*CFG_W +: SEL_W];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/wake_dp.sv
module wake_dp
  import wake_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int SEL_W   = 4,
  localparam int CFG_W  = SEL_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [NUM_SRC-1:0]      wakeSrc,
  output logic [FLAG_N-1:0]       flags,
  output logic [FLAG_N-1:0]       clrQ,
  output logic                    gateEn,
  output logic                    protoErr,
  output logic [PROG_N*CFG_W-1:0] cfgFlat,
  output logic                    wakeOut
);
  logic [PROG_N-1:0]  cfgEn;
  logic [SEL_W-1:0]   cfgSel [PROG_N];
  logic [NUM_SRC-1:0] srcQ;
  logic [NUM_SRC-1:0] rise;
  logic [PROG_N-1:0]  progSet;
  logic [SW_N-1:0]    swSet;
  logic [FLAG_N-1:0]  setVec;
  logic               unusedWrBits;

  assign unusedWrBits = ^wrData;
  assign rise = wakeSrc & ~srcQ;

  for (genvar i = 0; i < PROG_N; i++) begin : g_prog
    assign progSet[i] = cfgEn[i] & rise[cfgSel[i]];
    assign cfgFlat[i*CFG_W +: CFG_W] = {cfgEn[i], cfgSel[i]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgEn[i]  <= 1'b0;
        cfgSel[i] <= '0;
      end else if (strb.cfgLoad[i]) begin
        cfgEn[i]  <= wrData[DATA_W-1];
        cfgSel[i] <= wrData[SEL_W-1:0];
      end
    end
  end

  assign swSet   = strb.trigLoad ? wrData[SW_N-1:0] : '0;
  assign setVec  = {swSet, progSet};
  assign wakeOut = gateEn & (|flags);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ     <= '0;
      flags    <= '0;
      clrQ     <= '0;
      gateEn   <= 1'b1;
      protoErr <= 1'b0;
    end else begin
      srcQ  <= wakeSrc;
      // a held clear bit wins over any set request
      flags <= (flags | setVec) & ~clrQ;
      if (strb.clrLoad)   clrQ     <= wrData[FLAG_N-1:0];
      if (strb.gateLoad)  gateEn   <= wrData[0];
      if (strb.cfgReject) protoErr <= 1'b1;
    end
  end
endmodule

// File: rtl/wake_flag_ctrl.sv
module wake_flag_ctrl
  import wake_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int SEL_W  = $clog2(NUM_SRC),
  localparam int CFG_W  = SEL_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] wakeSrc,
  output logic               wakeOut,
  output logic [FLAG_N-1:0]  wakeFlags
);
  strobe_t                 strb;
  logic [FLAG_N-1:0]       flags;
  logic [FLAG_N-1:0]       clrQ;
  logic                    gateEn;
  logic                    protoErr;
  logic [PROG_N*CFG_W-1:0] cfgFlat;

  assign wakeFlags = flags;

  wake_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr), .gateEn(gateEn),
    .protoErr(protoErr), .flags(flags), .clrQ(clrQ), .cfgFlat(cfgFlat),
    .strb(strb), .rdData(rdData)
  );

  wake_dp #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .wakeSrc(wakeSrc),
    .flags(flags), .clrQ(clrQ), .gateEn(gateEn), .protoErr(protoErr),
    .cfgFlat(cfgFlat), .wakeOut(wakeOut)
  );
endmodule

// File: rtl/wake_flag_ctrl_chk.sv
module wake_flag_ctrl_chk
  import wake_pkg::*;
#(
  parameter int CFG_W = 5
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [ADDR_W-1:0]       wrAddr,
  input logic                    gateEn,
  input logic                    protoErr,
  input logic [FLAG_N-1:0]       flags,
  input logic [FLAG_N-1:0]       clrQ,
  input logic [PROG_N*CFG_W-1:0] cfgFlat,
  input logic                    wakeOut
);
  p_clear_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|clrQ) |=> ((flags & $past(clrQ)) == '0));

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|flags) |=> ((($past(flags) & ~flags) & ~$past(clrQ)) == '0));

  p_gate_closed_r7: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn |-> !wakeOut);

  p_gate_open_r7: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn && (|flags)) |-> wakeOut);

  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr < ADDR_W'(PROG_N)) && gateEn) |=> ($stable(cfgFlat) && protoErr));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

bind wake_flag_ctrl wake_flag_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .gateEn(gateEn),
  .protoErr(protoErr), .flags(flags), .clrQ(clrQ), .cfgFlat(cfgFlat),
  .wakeOut(wakeOut)
);

// File: tb/wake_flag_ctrl_tb.sv
module wake_flag_ctrl_tb;
  localparam int PERIOD  = 20;
  localparam int NUM_SRC = 16;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                wrEn = 1'b0;
  logic [2:0]          wrAddr = '0;
  logic [7:0]          wrData = '0;
  logic [2:0]          rdAddr = '0;
  logic [7:0]          rdData;
  logic [NUM_SRC-1:0]  wakeSrc = '0;
  logic                wakeOut;
  logic [7:0]          wakeFlags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [2:0] addr;
    logic [7:0] expRd;
    logic [7:0] expFlags;
    logic       expWake;
  } item_t;

  item_t itemQ[$];
  string tagQ[$];

  wake_flag_ctrl #(.NUM_SRC(NUM_SRC)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wakeSrc(wakeSrc),
    .wakeOut(wakeOut), .wakeFlags(wakeFlags)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic setSrc(input logic [NUM_SRC-1:0] v);
    @(negedge clk);
    wakeSrc = v;
  endtask

  // driver side of the scoreboard: push the expectation, let one edge pass
  task automatic chk(input string tag, input logic [2:0] a, input logic [7:0] rd,
                     input logic [7:0] fl, input logic wk);
    item_t it;
    it.addr = a; it.expRd = rd; it.expFlags = fl; it.expWake = wk;
    itemQ.push_back(it);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  // monitor side: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      while (itemQ.size() > 0) begin
        item_t it;
        string tg;
        it = itemQ.pop_front();
        tg = tagQ.pop_front();
        rdAddr = it.addr;
        #1;
        checks++;
        if (rdData !== it.expRd || wakeFlags !== it.expFlags || wakeOut !== it.expWake) begin
          errors++;
          $display("FAIL %s: rd=%h exp %h flags=%h exp %h wake=%b exp %b",
                   tg, rdData, it.expRd, wakeFlags, it.expFlags, wakeOut, it.expWake);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, all requirements");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 gate reset", 3'd7, 8'h01, 8'h00, 1'b0);
    chk("R1 config reset", 3'd0, 8'h00, 8'h00, 1'b0);
    chk("R1 clear reg reset", 3'd6, 8'h00, 8'h00, 1'b0);

    wr(3'd0, 8'h83);
    chk("R8 cfg write refused", 3'd0, 8'h00, 8'h00, 1'b0);
    chk("R8 error bit set", 3'd7, 8'h03, 8'h00, 1'b0);

    wr(3'd7, 8'h00);
    chk("R9 gate closed", 3'd7, 8'h02, 8'h00, 1'b0);
    wr(3'd0, 8'h83);
    wr(3'd1, 8'h05);
    chk("R9 cfg0 loaded", 3'd0, 8'h83, 8'h00, 1'b0);
    chk("R9 cfg1 loaded", 3'd1, 8'h05, 8'h00, 1'b0);
    wr(3'd7, 8'h01);

    setSrc(16'h0038);
    chk("R2 R3 edge on src3 only", 3'd5, 8'h01, 8'h01, 1'b1);

    wr(3'd4, 8'h05);
    chk("R4 trigger sets 4 and 6", 3'd5, 8'h51, 8'h51, 1'b1);
    wr(3'd4, 8'h00);
    chk("R10 zero trigger holds", 3'd5, 8'h51, 8'h51, 1'b1);

    wr(3'd6, 8'h10);
    chk("R5 sw flag cleared", 3'd5, 8'h41, 8'h41, 1'b1);
    wr(3'd4, 8'h01);
    chk("R6 sw set blocked", 3'd5, 8'h41, 8'h41, 1'b1);
    wr(3'd6, 8'h00);
    wr(3'd4, 8'h01);
    chk("R4 retrigger after release", 3'd5, 8'h51, 8'h51, 1'b1);

    wr(3'd7, 8'h00);
    chk("R7 gate closed masks output", 3'd7, 8'h02, 8'h51, 1'b0);
    wr(3'd6, 8'h01);
    chk("R5 hw flag cleared", 3'd5, 8'h50, 8'h50, 1'b0);
    setSrc(16'h0030);
    setSrc(16'h0038);
    chk("R6 hw set blocked", 3'd5, 8'h50, 8'h50, 1'b0);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h01);
    chk("R7 gate reopened", 3'd5, 8'h50, 8'h50, 1'b1);

    wr(3'd6, 8'hF0);
    chk("R5 clear all", 3'd5, 8'h00, 8'h00, 1'b0);
    wr(3'd6, 8'h00);
    chk("R2 held level no set", 3'd5, 8'h00, 8'h00, 1'b0);

    setSrc(16'h0018);
    setSrc(16'h0038);
    chk("R3 disabled cfg no set", 3'd5, 8'h00, 8'h00, 1'b0);

    wr(3'd7, 8'h00);
    wr(3'd1, 8'h85);
    wr(3'd7, 8'h01);
    chk("R9 cfg1 enabled", 3'd1, 8'h85, 8'h00, 1'b0);
    setSrc(16'h0018);
    setSrc(16'h0038);
    chk("R2 cfg1 edge", 3'd5, 8'h02, 8'h02, 1'b1);

    wr(3'd2, 8'h8F);
    chk("R8 cfg2 locked", 3'd2, 8'h00, 8'h02, 1'b1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule